// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the sequencer of a 10-bit successive-approximation converter. It runs in the conversion-clock domain. A serial front end asks for a conversion by flipping a start toggle. It also presents a 4-bit channel address. The sequencer then works through a fixed-length schedule. It drives a trial code to the external DAC and comparator. It takes one comparator decision per bit, starting with the most significant bit, and holds the finished code in a result register. A ready flag goes low while a conversion runs and high when the result is ready. A done toggle flips once per completed conversion, so the serial side can sense the completion with its own synchronizer.

The chip-select line is filtered on the falling edges of the conversion clock. A filtered falling edge that arrives during a conversion aborts it, and the previous result stays in place. Three reserved addresses run built-in self-tests. These force half-scale, zero and full-scale codes without looking at the comparator. The two addresses above them are flagged as illegal and convert to zero.

Top module: `sar_conv_seq`

## Requirements
- R1: When a conversion starts, the trial code clears to 0x000. Its first non-zero value is 0x200, and bits are then decided one per cycle from bit 9 down to bit 0. A bit stays set when the comparator input is 1.
- R2: `convReady` stays low for exactly 44 conversion-clock cycles for every conversion that completes.
- R3: `result` changes only in the final step of a conversion. In the same cycle `doneTgl` flips and `convReady` rises.
- R4: Each transition of `startTgl`, in either direction, starts one conversion when the block is idle. A transition that arrives while a conversion runs is ignored and gives no later conversion.
- R5: A new `csN` level is recognized only after it has been sampled on two consecutive falling clock edges. A low pulse seen on just one falling edge has no effect on a running conversion.
- R6: A recognized `csN` falling edge during a conversion returns the block to idle. `convReady` goes high, `doneTgl` does not flip and `result` keeps the previous value. This holds even in the final cycle. A recognized falling edge while idle has no effect.
- R7: Addresses 0x0 to 0xA are analog channels. The comparator model returns 1 when the input is at or above the trial code. The result is then the input clamped to the range 0x000 to 0x3FF, so inputs at or above full scale give 0x3FF and inputs at or below zero give 0x000.
- R8: Address 0xB gives 0x200, 0xC gives 0x000 and 0xD gives 0x3FF, whatever the comparator reports.
- R9: Addresses 0xE and 0xF give 0x000 and set `illegalAddr` from the start of that conversion until the next start. Any other address clears it.
- R10: After reset, `convReady`=1, `result`=0x000, `doneTgl`=0, `illegalAddr`=0 and `trialCode`=0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startTgl | input | 1 | Start request from the serial domain; every edge asks for one conversion |
| chanAddr | input | 4 | Channel or self-test address for the next conversion |
| compKeep | input | 1 | Comparator decision for the current trial code (1 = keep the bit) |
| csN | input | 1 | Active-low chip select, unfiltered |
| trialCode | output | 10 | Trial code presented to the DAC |
| result | output | 10 | Held result of the last completed conversion |
| convReady | output | 1 | Low while a conversion is in progress |
| doneTgl | output | 1 | Flips once for each completed conversion |
| illegalAddr | output | 1 | The current or last conversion used a reserved illegal address |

## Verification
The assertions assume several things about the inputs. `chanAddr` is stable before `startTgl` moves and stays so until the start is sampled. `compKeep` is a combinational function of the present `trialCode`, valid in the same cycle. `csN` changes away from the falling clock edge. The bench drives every input two nanoseconds after a rising edge and sets the address and input model before it flips the start toggle. Its comparator is an ideal threshold model of an integer input voltage. Chip-select pulses are shaped to cover either exactly one falling edge, the glitch case, or several, the abort case.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = 5;

  localparam logic [ADDR_W-1:0] ADDR_LAST_ANALOG = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_SELF_HALF   = 4'hB;
  localparam logic [ADDR_W-1:0] ADDR_SELF_ZERO   = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_SELF_FULL   = 4'hD;

  typedef enum logic [2:0] {
    MODE_ANALOG,
    MODE_HALF,
    MODE_ZERO,
    MODE_FULL,
    MODE_BAD
  } convMode_e;

  typedef struct packed {
    logic             start;
    logic             loadMsb;
    logic             decide;
    logic [IDX_W-1:0] bitIdx;
    logic             commit;
  } seqStrobe_t;

  function automatic convMode_e decodeMode(input logic [ADDR_W-1:0] addr);
    if (addr <= ADDR_LAST_ANALOG)    return MODE_ANALOG;
    else if (addr == ADDR_SELF_HALF) return MODE_HALF;
    else if (addr == ADDR_SELF_ZERO) return MODE_ZERO;
    else if (addr == ADDR_SELF_FULL) return MODE_FULL;
    else                             return MODE_BAD;
  endfunction
endpackage

// File: rtl/sar_tgl_sync.sv
module sar_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglIn,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], tglIn};
  end

  // one-cycle pulse on either polarity of the synchronized toggle
  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/sar_cs_filter.sv
module sar_cs_filter (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  output logic csFilt
);
  logic smpA, smpB;

  // sampled on falling edges; level accepted once two samples agree
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      smpA   <= 1'b1;
      smpB   <= 1'b1;
      csFilt <= 1'b1;
    end else begin
      smpA <= csN;
      smpB <= smpA;
      if (smpA == smpB) csFilt <= smpA;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int TOTAL = 44,
  parameter int PRE   = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       csFilt,
  output seqStrobe_t strb,
  output logic       convReady,
  output logic       doneTgl
);
  localparam int CNT_W   = $clog2(TOTAL);
  localparam int LAST    = TOTAL - 1;
  localparam int BIT_END = PRE + WIDTH;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             csFiltQ;
  logic             abortEvt;

  assign abortEvt = busy & csFiltQ & ~csFilt;

  always_comb begin
    strb         = '0;
    strb.start   = startPulse & ~busy;
    strb.loadMsb = busy && (cnt == CNT_W'(PRE - 1));
    strb.decide  = busy && (cnt >= CNT_W'(PRE)) && (cnt < CNT_W'(BIT_END));
    if (strb.decide) strb.bitIdx = IDX_W'(BIT_END - 1 - int'(cnt));
    strb.commit  = busy && (cnt == CNT_W'(LAST)) && !abortEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      convReady <= 1'b1;
      doneTgl   <= 1'b0;
      csFiltQ   <= 1'b1;
    end else begin
      csFiltQ <= csFilt;
      if (abortEvt) begin
        busy      <= 1'b0;
        cnt       <= '0;
        convReady <= 1'b1;
      end else if (strb.start) begin
        busy      <= 1'b1;
        cnt       <= '0;
        convReady <= 1'b0;
      end else if (busy) begin
        if (strb.commit) begin
          busy      <= 1'b0;
          cnt       <= '0;
          convReady <= 1'b1;
          doneTgl   <= ~doneTgl;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              compKeep,
  output logic [WIDTH-1:0]  trialCode,
  output logic [WIDTH-1:0]  result,
  output logic              illegalAddr
);
  localparam logic [WIDTH-1:0] ONE_HOT_LSB = WIDTH'(1);
  localparam logic [WIDTH-1:0] MSB_MASK    = ONE_HOT_LSB << (WIDTH - 1);

  convMode_e        mode;
  convMode_e        nextMode;
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] nextMask;
  logic             keep;

  assign nextMode = decodeMode(chanAddr);
  assign bitMask  = ONE_HOT_LSB << strb.bitIdx;
  assign nextMask = bitMask >> 1;

  always_comb begin
    unique case (mode)
      MODE_ANALOG: keep = compKeep;
      MODE_HALF:   keep = bitMask[WIDTH-1];
      MODE_FULL:   keep = 1'b1;
      default:     keep = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode   <= '0;
      result      <= '0;
      mode        <= MODE_ANALOG;
      illegalAddr <= 1'b0;
    end else begin
      if (strb.start) begin
        trialCode   <= '0;
        mode        <= nextMode;
        illegalAddr <= (nextMode == MODE_BAD);
      end
      if (strb.loadMsb) trialCode <= MSB_MASK;
      if (strb.decide)
        trialCode <= (keep ? trialCode : (trialCode & ~bitMask)) | nextMask;
      if (strb.commit) result <= trialCode;
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH        = 10,
  parameter int TOTAL_CYCLES = 44,
  parameter int PRE_CYCLES   = 17,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startTgl,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              compKeep,
  input  logic              csN,
  output logic [WIDTH-1:0]  trialCode,
  output logic [WIDTH-1:0]  result,
  output logic              convReady,
  output logic              doneTgl,
  output logic              illegalAddr
);
  seqStrobe_t strb;
  logic       startPulse;
  logic       csFilt;

  sar_tgl_sync #(.STAGES(SYNC_STAGES)) startSync_i (
    .clk(clk), .rstN(rstN), .tglIn(startTgl), .pulse(startPulse)
  );

  sar_cs_filter csFilter_i (
    .clk(clk), .rstN(rstN), .csN(csN), .csFilt(csFilt)
  );

  sar_seq_ctrl #(.WIDTH(WIDTH), .TOTAL(TOTAL_CYCLES), .PRE(PRE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .csFilt(csFilt),
    .strb(strb), .convReady(convReady), .doneTgl(doneTgl)
  );

  sar_seq_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .chanAddr(chanAddr),
    .compKeep(compKeep), .trialCode(trialCode), .result(result),
    .illegalAddr(illegalAddr)
  );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int WIDTH = 10,
  parameter int TOTAL = 44
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] trialCode,
  input logic [WIDTH-1:0] result,
  input logic             convReady,
  input logic             doneTgl,
  input logic             illegalAddr
);
  localparam int LCW = $clog2(TOTAL) + 2;
  logic [LCW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowCnt <= '0;
    else if (convReady) lowCnt <= '0;
    else                lowCnt <= lowCnt + LCW'(1);
  end

  assert_busy_span_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doneTgl != $past(doneTgl)) |-> (lowCnt == LCW'(TOTAL)));

  assert_result_at_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> (doneTgl != $past(doneTgl)));

  assert_done_with_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doneTgl != $past(doneTgl)) |-> $rose(convReady));

  assert_abort_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convReady) && (doneTgl == $past(doneTgl))) |-> $stable(result));

  assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (illegalAddr && (doneTgl != $past(doneTgl))) |-> (result == '0));

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convReady) |-> (trialCode == '0));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WIDTH(WIDTH), .TOTAL(TOTAL_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .trialCode(trialCode), .result(result),
  .convReady(convReady), .doneTgl(doneTgl), .illegalAddr(illegalAddr)
);

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;
  localparam int WIDTH = 10;
  localparam int TOTAL = 44;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rstN     = 1'b0;
  logic             startTgl = 1'b0;
  logic             csN      = 1'b1;
  logic [3:0]       chanAddr = 4'h0;
  int               vinModel = 0;
  logic [WIDTH-1:0] trialCode, result;
  logic             convReady, doneTgl, illegalAddr;
  logic             compKeep;

  assign compKeep = (vinModel >= int'(trialCode));

  sar_conv_seq dut_i (
    .clk(clk), .rstN(rstN), .startTgl(startTgl), .chanAddr(chanAddr),
    .compKeep(compKeep), .csN(csN), .trialCode(trialCode), .result(result),
    .convReady(convReady), .doneTgl(doneTgl), .illegalAddr(illegalAddr)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          finished = 0;
  logic [10:0] expQ[$];
  string       tagQ[$];
  logic        doneSeen = 1'b0;
  int          lastExp  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int expectCode(input logic [3:0] a, input int vin);
    case (a)
      4'hB: return 'h200;
      4'hC: return 'h000;
      4'hD: return 'h3FF;
      4'hE, 4'hF: return 0;
      default: return (vin < 0) ? 0 : ((vin > 1023) ? 1023 : vin);
    endcase
  endfunction

  task automatic stepIn();
    @(posedge clk);
    #2;
  endtask

  // driver: set inputs, push expected item, flip start, time the busy window
  task automatic runConv(input logic [3:0] a, input int vin, input string tag);
    int  cnt;
    bit  seen;
    stepIn();
    chanAddr = a;
    vinModel = vin;
    expQ.push_back({(a >= 4'hE), 10'(expectCode(a, vin))});
    tagQ.push_back(tag);
    startTgl = ~startTgl;
    for (int i = 0; i < 20 && convReady; i++) @(negedge clk);
    check(!convReady, "R4 start accepted", int'(convReady), 0);
    check(trialCode == '0, "R1 trial cleared at start", int'(trialCode), 0);
    cnt  = 0;
    seen = 0;
    while (!convReady && cnt < 200) begin
      if (!seen && trialCode != '0) begin
        seen = 1;
        check(trialCode == 10'h200, "R1 MSB tried first", int'(trialCode), 'h200);
      end
      cnt++;
      @(negedge clk);
    end
    check(cnt == TOTAL, "R2 busy length", cnt, TOTAL);
  endtask

  // monitor: pop and compare on each completion
  initial begin
    logic [10:0] e;
    string       t;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (doneTgl !== doneSeen) begin
        doneSeen = doneTgl;
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected completion", 1, 0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(result == e[9:0], {t, " result"}, int'(result), int'(e[9:0]));
          check(illegalAddr == e[10], "R9 illegal flag", int'(illegalAddr), int'(e[10]));
          lastExp = int'(e[9:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(convReady == 1'b1, "R10 reset ready", int'(convReady), 1);
    check(result == '0, "R10 reset result", int'(result), 0);
    check(doneTgl == 1'b0, "R10 reset done toggle", int'(doneTgl), 0);
    check(illegalAddr == 1'b0, "R10 reset illegal flag", int'(illegalAddr), 0);
    check(trialCode == '0, "R10 reset trial", int'(trialCode), 0);
    stepIn();
    rstN = 1'b1;
    repeat (3) stepIn();

    // R7 analog channels, including clamping at both ends
    runConv(4'h0, 0, "R7 zero input");
    runConv(4'h1, 1, "R7 one LSB");
    runConv(4'h5, 512, "R7 mid scale");
    runConv(4'h7, 700, "R7 arbitrary code");
    runConv(4'hA, 1023, "R7 full scale");
    runConv(4'h3, 2000, "R7 above top saturates");
    runConv(4'h2, -40, "R7 below bottom gives zero");
    runConv(4'h9, 341, "R7 alternating bits");

    // R8 self-test codes ignore the comparator
    runConv(4'hB, 7, "R8 half scale test");
    runConv(4'hC, 900, "R8 zero test");
    runConv(4'hD, 3, "R8 full scale test");

    // R9 illegal addresses, then a legal one clears the flag
    runConv(4'hE, 600, "R9 illegal E");
    runConv(4'hF, 600, "R9 illegal F");
    runConv(4'h4, 100, "R9 flag cleared");

    // R4 a start edge during a conversion is dropped
    fork
      runConv(4'h6, 250, "R4 base conversion");
      begin
        repeat (10) stepIn();
        startTgl = ~startTgl;
      end
    join
    repeat (80) @(negedge clk);
    check(convReady && expQ.size() == 0, "R4 start during busy ignored",
          int'(convReady), 1);
    check(doneTgl == doneSeen, "R4 no extra completion", int'(doneTgl), int'(doneSeen));

    // R5 chip-select glitch covering one falling edge
    fork
      runConv(4'h8, 300, "R5 glitch ignored");
      begin
        repeat (12) stepIn();
        csN = 1'b0;
        stepIn();
        csN = 1'b1;
      end
    join
    repeat (5) stepIn();

    // R6 abort during a conversion keeps the previous result
    begin
      logic prevDone;
      int   prevRes;
      prevDone = doneTgl;
      prevRes  = lastExp;
      stepIn();
      chanAddr = 4'h3;
      vinModel = 999;
      startTgl = ~startTgl;
      for (int i = 0; i < 20 && convReady; i++) @(negedge clk);
      check(!convReady, "R6 conversion started before abort", int'(convReady), 0);
      repeat (8) stepIn();
      csN = 1'b0;
      repeat (6) @(negedge clk);
      check(convReady == 1'b1, "R6 abort returns to idle", int'(convReady), 1);
      check(int'(result) == prevRes, "R6 previous result kept", int'(result), prevRes);
      check(doneTgl == prevDone, "R6 no done toggle on abort", int'(doneTgl), int'(prevDone));
      stepIn();
      csN = 1'b1;
      repeat (60) @(negedge clk);
      check(int'(result) == prevRes && convReady, "R6 still idle after abort",
            int'(result), prevRes);

      // R6 a recognized falling edge while idle does nothing
      stepIn();
      csN = 1'b0;
      repeat (6) @(negedge clk);
      check(convReady == 1'b1, "R6 idle chip select keeps ready", int'(convReady), 1);
      check(int'(result) == prevRes, "R6 idle chip select keeps result", int'(result), prevRes);
      stepIn();
      csN = 1'b1;
      repeat (6) stepIn();
    end

    runConv(4'h1, 777, "R3 recovery after abort");
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3 all conversions reported", expQ.size(), 0);
    finishUp();
  end
endmodule